// File: doc/BRIEF.md
# Shifted-Register Add/Subtract Execute Unit

This unit executes one class of integer instruction: an add or a subtract whose second operand is a register shifted by an immediate amount. It receives a 32-bit instruction word together with the values already read for its two source registers. It checks that the word belongs to this class and rejects reserved or out-of-range encodings. It shifts the second operand by the immediate amount and adds or subtracts in 32-bit or 64-bit width. When the word asks for it, the unit also produces the negative, zero, carry and overflow condition flags.

The register file sits outside the unit. Source register values arrive as 64-bit operands. The unit returns the destination index, a 64-bit result, a write enable for that result, a flag vector with its own write enable, and two rejection indicators. A word from another class raises the foreign-class indicator. A word of this class that uses a forbidden encoding raises the illegal-encoding indicator. Every output is registered, and a valid strobe marks the cycle in which the outputs belong to a word.

Top module: `addsub_shreg_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier. While `rst` (synchronous, active high) is asserted at a clock edge, `out_valid` is cleared at that edge.
- R2: A valid word whose bits 28:24 are not 01011, or whose bit 21 is 1, produces `out_not_class`=1, `out_illegal`=0, `out_wr_en`=0 and `out_flags_we`=0.
- R3: A word of this class whose shift field (bits 23:22) is 11 produces `out_illegal`=1 and no result or flag write.
- R4: A word of this class with bit 31 = 0 (32-bit width) and bit 15 = 1 (shift amount above 31) produces `out_illegal`=1 and no result or flag write. With bit 31 = 1, any amount from 0 to 63 is legal.
- R5: For a legal word, bit 30 = 0 selects first operand plus shifted second operand, and bit 30 = 1 selects first operand minus shifted second operand. `out_rd` carries bits 4:0 of the word and `out_wr_en`=1.
- R6: Shift field 00 shifts the second operand left by bits 15:10, and shift field 01 shifts it right logically by the same amount, both before the add or subtract.
- R7: Shift field 10 shifts the second operand right arithmetically, replicating bit 63 in 64-bit width and bit 31 in 32-bit width.
- R8: Bit 31 = 1 selects 64-bit width. Bit 31 = 0 uses only the low 32 bits of both operands and returns the 32-bit result zero-extended, so bits 63:32 of `out_result` are 0.
- R9: With bit 29 = 1, `out_flags_we`=1 and `out_flags` = {N,Z,C,V} at the operation width, in bits 3,2,1,0. N is the top result bit and Z marks a zero result. C is the carry out for an add and the absence of a borrow for a subtract. V is signed overflow.
- R10: With bit 29 = 0, `out_flags_we`=0 and `out_flags` is 0.
- R11: Exactly one of `out_wr_en`, `out_illegal` and `out_not_class` is 1 in a valid cycle. In any other case the fields that do not apply (result, index, flags) are 0, and every output besides `out_valid` is 0 when `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present |
| in_insn | input | 32 | Instruction word |
| in_rn_val | input | 64 | Value of the first source register |
| in_rm_val | input | 64 | Value of the register to be shifted |
| out_valid | output | 1 | Outputs belong to the word accepted one cycle earlier |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Result, zero-extended in 32-bit width |
| out_wr_en | output | 1 | Result is to be written to `out_rd` |
| out_flags | output | 4 | N, Z, C, V in bits 3 to 0 |
| out_flags_we | output | 1 | Condition flags are to be updated |
| out_illegal | output | 1 | Word is of this class but its encoding is forbidden |
| out_not_class | output | 1 | Word is not an add/subtract shifted-register word |

## Verification
Rejection of a forbidden encoding and the flag update can both apply to one word. This happens when a word requests flags (bit 29 = 1) and also carries the reserved shift field, or carries a 32-bit shift amount of 32 or more. Directed words combine both conditions, including a word that breaks both encoding rules at once. The expected outcome is the illegal indicator with no flag write, zero flags and no result write. Back-to-back valid words with idle gaps between them check that one word's rejection does not leak into the next word's flags or result.

// File: rtl/addsub_shreg_pkg.sv
package addsub_shreg_pkg;

    // Shift field encoding; the reserved code is rejected by decode
    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_RSV = 2'b11
    } shift_kind_e;

    localparam logic [4:0] CLASS_TAG = 5'b01011;
    localparam int         AMT_W     = 6;
    localparam int         IDX_W     = 5;

    typedef struct packed {
        logic              is_class;
        logic              bad;
        logic              wide;
        logic              sub;
        logic              set_flags;
        shift_kind_e       kind;
        logic [AMT_W-1:0]  amount;
        logic [IDX_W-1:0]  dst;
    } dec_fields_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/addsub_shreg_decode.sv
module addsub_shreg_decode
    import addsub_shreg_pkg::*;
(
    input  logic [31:0] word,
    output dec_fields_t fields
);

    always_comb begin
        fields           = '0;
        fields.is_class  = (word[28:24] == CLASS_TAG) && !word[21];
        fields.wide      = word[31];
        fields.sub       = word[30];
        fields.set_flags = word[29];
        fields.kind      = shift_kind_e'(word[23:22]);
        fields.amount    = word[15:10];
        fields.dst       = word[4:0];
        // reserved shift code, or a narrow shift of 32 or more
        fields.bad       = (fields.kind == SH_RSV) ||
                           (!fields.wide && fields.amount[AMT_W-1]);
    end

endmodule

// File: rtl/addsub_shreg_shifter.sv
module addsub_shreg_shifter
    import addsub_shreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] val,
    input  logic              wide,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] shifted
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] lo_zext;
    logic [DATA_W-1:0] lo_sext;

    assign lo_zext = {{HALF_W{1'b0}}, val[HALF_W-1:0]};
    assign lo_sext = {{HALF_W{val[HALF_W-1]}}, val[HALF_W-1:0]};

    always_comb begin
        unique case (kind)
            SH_LSL:  shifted = wide ? (val << amount) : ((lo_zext << amount) & LO_MASK);
            SH_LSR:  shifted = wide ? (val >> amount) : (lo_zext >> amount);
            SH_ASR:  shifted = wide ? DATA_W'($signed(val) >>> amount)
                                    : (DATA_W'($signed(lo_sext) >>> amount) & LO_MASK);
            default: shifted = '0;
        endcase
    end

endmodule

// File: rtl/addsub_shreg_alu.sv
module addsub_shreg_alu
    import addsub_shreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              wide,
    input  logic              sub,
    output logic [DATA_W-1:0] result,
    output nzcv_t             flags
);

    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;

    logic [DATA_W-1:0] lane_res [LANES];
    nzcv_t             lane_flg [LANES];

    // lane 0 works at half width, lane 1 at full width
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 1) ? DATA_W : HALF_W;

        logic [LW-1:0] x;
        logic [LW-1:0] y;
        logic [LW:0]   total;

        assign x     = opa[LW-1:0];
        assign y     = sub ? ~opb[LW-1:0] : opb[LW-1:0];
        assign total = {1'b0, x} + {1'b0, y} + {{LW{1'b0}}, sub};

        assign lane_res[g]   = DATA_W'(total[LW-1:0]);
        assign lane_flg[g].n = total[LW-1];
        assign lane_flg[g].z = (total[LW-1:0] == '0);
        assign lane_flg[g].c = total[LW];
        assign lane_flg[g].v = (x[LW-1] == y[LW-1]) && (total[LW-1] != x[LW-1]);
    end

    assign result = wide ? lane_res[1] : lane_res[0];
    assign flags  = wide ? lane_flg[1] : lane_flg[0];

endmodule

// File: rtl/addsub_shreg_unit.sv
module addsub_shreg_unit
    import addsub_shreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [DATA_W-1:0] in_rn_val,
    input  logic [DATA_W-1:0] in_rm_val,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_rd,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic [3:0]        out_flags,
    output logic              out_flags_we,
    output logic              out_illegal,
    output logic              out_not_class
);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  rd;
        logic [DATA_W-1:0] res;
        logic              wr;
        nzcv_t             flags;
        logic              fwe;
        logic              illegal;
        logic              foreign;
    } stage_t;

    dec_fields_t       dec;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] sum;
    nzcv_t             sum_flags;
    stage_t            st_d;
    stage_t            st_q;

    addsub_shreg_decode u_decode (
        .word   (in_insn),
        .fields (dec)
    );

    addsub_shreg_shifter #(.DATA_W(DATA_W)) u_shifter (
        .val     (in_rm_val),
        .wide    (dec.wide),
        .kind    (dec.kind),
        .amount  (dec.amount),
        .shifted (shifted)
    );

    addsub_shreg_alu #(.DATA_W(DATA_W)) u_alu (
        .opa    (in_rn_val),
        .opb    (shifted),
        .wide   (dec.wide),
        .sub    (dec.sub),
        .result (sum),
        .flags  (sum_flags)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            if (!dec.is_class) begin
                st_d.foreign = 1'b1;
            end else if (dec.bad) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.wr  = 1'b1;
                st_d.rd  = dec.dst;
                st_d.res = sum;
                if (dec.set_flags) begin
                    st_d.fwe   = 1'b1;
                    st_d.flags = sum_flags;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign out_rd        = st_q.rd;
    assign out_result    = st_q.res;
    assign out_wr_en     = st_q.wr;
    assign out_flags     = st_q.flags;
    assign out_flags_we  = st_q.fwe;
    assign out_illegal   = st_q.illegal;
    assign out_not_class = st_q.foreign;

endmodule

// File: rtl/addsub_shreg_unit_chk.sv
module addsub_shreg_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [31:0]       in_insn,
    input logic              out_valid,
    input logic [4:0]        out_rd,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wr_en,
    input logic [3:0]        out_flags,
    input logic              out_flags_we,
    input logic              out_illegal,
    input logic              out_not_class
);

    logic in_class;
    assign in_class = (in_insn[28:24] == 5'b01011) && !in_insn[21];

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_foreign_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_class) |=> (out_not_class && !out_illegal && !out_wr_en && !out_flags_we));

    assert_reserved_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class && in_insn[23:22] == 2'b11) |=> (out_illegal && !out_wr_en && !out_flags_we));

    assert_narrow_range_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class && !in_insn[31] && in_insn[15]) |=> (out_illegal && !out_wr_en && !out_flags_we));

    assert_dest_index_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class && in_insn[23:22] != 2'b11 && (in_insn[31] || !in_insn[15]))
        |=> (out_wr_en && out_rd == $past(in_insn[4:0])));

    assert_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class && !in_insn[31]) |=> (out_result[DATA_W-1:DATA_W/2] == '0));

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        out_flags_we |-> (out_flags[2] == (out_result == '0)));

    assert_no_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_insn[29]) |=> (!out_flags_we && out_flags == 4'd0));

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones({out_wr_en, out_illegal, out_not_class}) == 1));

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_wr_en && !out_illegal && !out_not_class && !out_flags_we
                        && out_result == '0 && out_flags == 4'd0 && out_rd == 5'd0));

endmodule

bind addsub_shreg_unit addsub_shreg_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/addsub_shreg_unit_tb.sv
module addsub_shreg_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [63:0] in_rn_val = '0;
    logic [63:0] in_rm_val = '0;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic [63:0] out_result;
    logic        out_wr_en;
    logic [3:0]  out_flags;
    logic        out_flags_we;
    logic        out_illegal;
    logic        out_not_class;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    addsub_shreg_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_rn_val(in_rn_val), .in_rm_val(in_rm_val), .out_valid(out_valid),
        .out_rd(out_rd), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_flags(out_flags), .out_flags_we(out_flags_we),
        .out_illegal(out_illegal), .out_not_class(out_not_class)
    );

    typedef struct packed {
        logic        v;
        logic [4:0]  rd;
        logic [63:0] res;
        logic        wr;
        logic [3:0]  fl;
        logic        fwe;
        logic        ill;
        logic        nc;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic [31:0] mk(logic sf, logic op, logic s, logic [1:0] st,
                                       logic [5:0] amt, logic [4:0] rd);
        return {sf, op, s, 5'b01011, st, 1'b0, 5'd7, amt, 5'd3, rd};
    endfunction

    function automatic exp_t model(logic v, logic [31:0] w, logic [63:0] a, logic [63:0] b);
        exp_t e = '0;
        logic [63:0] sb, r;
        logic [31:0] a32, b32, sb32, r32;
        logic n, z, c, ov;
        int amt;
        if (!v) return e;
        e.v = 1'b1;
        if (w[28:24] != 5'b01011 || w[21]) begin e.nc = 1'b1; return e; end
        if (w[23:22] == 2'b11 || (!w[31] && w[15])) begin e.ill = 1'b1; return e; end
        amt  = int'(w[15:10]);
        e.rd = w[4:0];
        e.wr = 1'b1;
        if (w[31]) begin
            case (w[23:22])
                2'b00:   sb = b << amt;
                2'b01:   sb = b >> amt;
                default: sb = $signed(b) >>> amt;
            endcase
            r  = w[30] ? a - sb : a + sb;
            c  = w[30] ? (a >= sb) : (r < a);
            ov = w[30] ? (a[63] != sb[63] && r[63] != a[63]) : (a[63] == sb[63] && r[63] != a[63]);
            n  = r[63];
            e.res = r;
        end else begin
            a32 = a[31:0];
            b32 = b[31:0];
            case (w[23:22])
                2'b00:   sb32 = b32 << amt;
                2'b01:   sb32 = b32 >> amt;
                default: sb32 = $signed(b32) >>> amt;
            endcase
            r32 = w[30] ? a32 - sb32 : a32 + sb32;
            c   = w[30] ? (a32 >= sb32) : (r32 < a32);
            ov  = w[30] ? (a32[31] != sb32[31] && r32[31] != a32[31])
                        : (a32[31] == sb32[31] && r32[31] != a32[31]);
            n   = r32[31];
            e.res = {32'd0, r32};
        end
        z = (e.res == 64'd0);
        if (w[29]) begin
            e.fwe = 1'b1;
            e.fl  = {n, z, c, ov};
        end
        return e;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one item per cycle, valid or idle
    task automatic drive(logic v, logic [31:0] w, logic [63:0] a, logic [63:0] b);
        @(posedge clk);
        #2;
        in_valid  = v;
        in_insn   = w;
        in_rn_val = a;
        in_rm_val = b;
        sb_q.push_back(model(v, w, a, b));
    endtask

    // monitor: the output seen now belongs to the item before the newest
    always @(negedge clk) begin
        if (sb_q.size() >= 2) begin
            exp_t e;
            e = sb_q.pop_front();
            check("R1 out_valid",      64'(out_valid),     64'(e.v));
            check("R2 out_not_class",  64'(out_not_class), 64'(e.nc));
            check("R3/R4 out_illegal", 64'(out_illegal),   64'(e.ill));
            check("R5 out_wr_en",      64'(out_wr_en),     64'(e.wr));
            check("R5 out_rd",         64'(out_rd),        64'(e.rd));
            check("R6/R7/R8 out_result", out_result,       e.res);
            check("R9 out_flags",      64'(out_flags),     64'(e.fl));
            check("R10 out_flags_we",  64'(out_flags_we),  64'(e.fwe));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state while valid is held high
        in_valid = 1'b1;
        in_insn  = mk(1'b1, 1'b0, 1'b1, 2'b00, 6'd0, 5'd1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R11 reset out_wr_en", 64'(out_wr_en), 64'd0);
        @(posedge clk);
        #2;
        rst = 1'b0;
        in_valid = 1'b0;

        // R5 R6: add, 64-bit, left shift by 4
        drive(1, mk(1, 0, 0, 2'b00, 6'd4, 5'd9), 64'd100, 64'd3);
        // R5 R9: subtract equal values -> Z and C set
        drive(1, mk(1, 1, 1, 2'b00, 6'd0, 5'd2), 64'd5, 64'd5);
        // R7: arithmetic right of the 64-bit sign bit, add one -> zero, carry
        drive(1, mk(1, 0, 1, 2'b10, 6'd63, 5'd4), 64'd1, 64'h8000_0000_0000_0000);
        drive(0, 32'h0, 64'h0, 64'h0);
        // R7 R8: arithmetic right at 32 bits, garbage in upper bits ignored
        drive(1, mk(0, 0, 1, 2'b10, 6'd4, 5'd5), 64'hFFFF_0000_0000_0000, 64'h1234_5678_8000_0000);
        // R8 R9: 32-bit signed overflow
        drive(1, mk(0, 0, 1, 2'b00, 6'd0, 5'd6), 64'hAAAA_AAAA_7FFF_FFFF, 64'h5555_5555_0000_0001);
        // R6: logical right, 64-bit
        drive(1, mk(1, 0, 0, 2'b01, 6'd1, 5'd7), 64'd0, 64'hF000_0000_0000_0001);
        // R3: reserved shift with flag request
        drive(1, mk(1, 0, 1, 2'b11, 6'd0, 5'd8), 64'd1, 64'd1);
        // R4: narrow amount of 32 with flag request
        drive(1, mk(0, 1, 1, 2'b00, 6'd32, 5'd8), 64'd1, 64'd1);
        // R3 R4 together
        drive(1, mk(0, 0, 1, 2'b11, 6'd40, 5'd8), 64'd1, 64'd1);
        // R4: wide amount 63 is legal
        drive(1, mk(1, 0, 1, 2'b00, 6'd63, 5'd10), 64'd0, 64'd1);
        // R2: bit 21 set, then another class tag
        drive(1, mk(1, 0, 1, 2'b00, 6'd0, 5'd11) | 32'h0020_0000, 64'd1, 64'd1);
        drive(1, (mk(1, 0, 1, 2'b00, 6'd0, 5'd11) & ~32'h1F00_0000) | 32'h0A00_0000, 64'd1, 64'd1);
        // R10: subtract with borrow, no flag request
        drive(1, mk(1, 1, 0, 2'b00, 6'd0, 5'd12), 64'd3, 64'd9);
        // R8 R10: narrow subtract with borrow
        drive(1, mk(0, 1, 0, 2'b01, 6'd31, 5'd13), 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_8000_0000);
        drive(0, 32'h0, 64'h0, 64'h0);
        drive(0, 32'h0, 64'h0, 64'h0);

        // mixed stream; R11 covered by every item
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            logic [63:0] a, b;
            w = $urandom;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ((i % 8) != 0) begin
                w[28:24] = 5'b01011;
                w[21]    = 1'b0;
            end
            if ((i % 5) == 0) a[31:0] = b[31:0];
            drive(($urandom % 4) != 0, w, a, b);
        end

        drive(0, 32'h0, 64'h0, 64'h0);
        drive(0, 32'h0, 64'h0, 64'h0);
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule